// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block is a clocked host-side controller for an external asynchronous static RAM of 64K words by 16 bits. It takes single-word read and write requests from a host and turns each one into the sequence of active-low control levels the memory expects. Those controls are chip select, write strobe, output enable and one enable per byte lane. The block also holds the address steady and drives the write data through a separate output, input and driver-enable trio.

Every phase of an access lasts a whole number of clock cycles. Each count is derived at elaboration from a nanosecond limit and the clock period: the limit is divided by the period, rounded up, with a floor of one cycle. A write passes through three phases: address set-up, strobe low, and hold. A read passes through two: an access window with output enable low, then a recovery window in which the memory's drivers float off the bus. A transaction is never allowed to finish before the memory's minimum cycle time.

Request side: a transfer happens on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while the controller is idle, so a held `req_valid` simply waits. The host must keep the request fields stable until that edge. The read-data return has no back-pressure: `rsp_valid` is a one-cycle pulse and the host must take `rsp_rdata` on that cycle.

Top module: `sram_ctl`

## Requirements
- R1: Out of reset and whenever idle, chip select, write strobe, output enable and both lane enables are high, the data driver is off, `rsp_valid` is low and `req_ready` is high.
- R2: A request is taken only on an edge with `req_valid` and `req_ready` high. `req_ready` is low from the next cycle until the transaction ends. With the 10 ns default period it stays low for 6 cycles on a write and 8 cycles on a read.
- R3: A write drives address and data with chip select low for 1 set-up cycle. The write strobe is then low for 4 cycles (the largest of strobe width, data set-up, and address-to-end minus set-up). Then comes 1 hold cycle with the strobe high, chip select still low and data still driven.
- R4: Every write ends by the write strobe rising while chip select is still low. The write strobe is low only while chip select is low and output enable is high.
- R5: A read holds chip select and output enable low with the write strobe high for 6 cycles. This is the larger of the address-to-data and enable-to-data limits.
- R6: Read data is sampled on the last access cycle and presented with `rsp_valid` high for exactly one cycle, the cycle after the access ends.
- R7: Mask bit 0 enables the low lane (data bits 7..0, pin `mem_lb_n`). Mask bit 1 enables the high lane (bits 15..8, pin `mem_ub_n`). A disabled lane's pin stays high for the whole transaction, a write leaves that lane of memory unchanged, and a read returns zero in it. A mask of 0 transfers nothing.
- R8: The data driver is never on while output enable is low. Output enable has been high for at least 2 cycles (the float time) before the driver turns on.
- R9: The memory address does not change while chip select stays low.
- R10: The write cycle and read cycle both meet the 55 ns minimum cycle time, counted by a separate cycle timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Byte-lane enables, bit 0 = bits 7..0 |
| rsp_valid | output | 1 | One-cycle read-data strobe |
| rsp_rdata | output | 16 | Read data, disabled lanes zero |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_lb_n | output | 1 | Low-lane enable, active low |
| mem_ub_n | output | 1 | High-lane enable, active low |
| mem_addr | output | 16 | Memory address |
| mem_dq_out | output | 16 | Data to the memory |
| mem_dq_in | input | 16 | Data from the memory |
| mem_dq_oe | output | 1 | Data driver enable |

## Verification
The bound checker watches, on every cycle, the pin relations that must never break. It checks that the strobe is low only inside a selected, output-disabled window and that every write ends by the strobe rising. It checks that the driver is never on while output enable is low, that the bus has floated long enough before the driver turns on, that the strobe's low time meets its minimum, that the address holds while selected, and that the handshake and response-pulse shapes are correct. Whether data actually lands in the right lanes and comes back correctly can only be shown by the bench scenarios. The same holds for disabled lanes reading as zero and for the exact busy lengths of each transaction type. The bench covers these with a memory model driven through partial masks, an empty mask and a write that follows a read.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WSETUP,
    ST_WPULSE,
    ST_WHOLD,
    ST_RACC,
    ST_RRECOV,
    ST_CWAIT
  } st_e;

  // ceiling of ns / period, never below one cycle
  function automatic int ns2cyc(input int ns, input int per);
    int c;
    c = (ns + per - 1) / per;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_ctl_cnt.sv
module sram_ctl_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] val,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (load)          cnt <= val;
    else if (cnt != '0)     cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/sram_ctl_pins.sv
module sram_ctl_pins
  import sram_ctl_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  st_e              nxt,
  input  logic [LANES-1:0] mask,
  output logic             ce_n,
  output logic             we_n,
  output logic             oe_n,
  output logic [LANES-1:0] lane_n,
  output logic             dq_oe
);
  logic sel, wr;

  always_comb begin
    sel = (nxt == ST_WSETUP) || (nxt == ST_WPULSE) || (nxt == ST_WHOLD) || (nxt == ST_RACC);
    wr  = (nxt == ST_WSETUP) || (nxt == ST_WPULSE) || (nxt == ST_WHOLD);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_n  <= 1'b1;
      we_n  <= 1'b1;
      oe_n  <= 1'b1;
      dq_oe <= 1'b0;
    end else begin
      ce_n  <= !sel;
      we_n  <= !(nxt == ST_WPULSE);
      oe_n  <= !(nxt == ST_RACC);
      dq_oe <= wr;
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lane_n[l] <= 1'b1;
      else        lane_n[l] <= !(sel && mask[l]);
    end
  end
endmodule

// File: rtl/sram_ctl.sv
module sram_ctl
  import sram_ctl_pkg::*;
#(
  parameter int CLK_NS   = 10,
  parameter int T_WC_NS  = 55,
  parameter int T_AW_NS  = 45,
  parameter int T_PWE_NS = 40,
  parameter int T_SD_NS  = 25,
  parameter int T_SA_NS  = 0,
  parameter int T_HA_NS  = 0,
  parameter int T_RC_NS  = 55,
  parameter int T_AA_NS  = 55,
  parameter int T_DOE_NS = 25,
  parameter int T_HZ_NS  = 20,
  parameter int CNT_W    = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_write,
  input  logic [15:0] req_addr,
  input  logic [15:0] req_wdata,
  input  logic [1:0]  req_mask,
  output logic        rsp_valid,
  output logic [15:0] rsp_rdata,
  output logic        mem_ce_n,
  output logic        mem_we_n,
  output logic        mem_oe_n,
  output logic        mem_lb_n,
  output logic        mem_ub_n,
  output logic [15:0] mem_addr,
  output logic [15:0] mem_dq_out,
  input  logic [15:0] mem_dq_in,
  output logic        mem_dq_oe
);
  localparam int LANES = 2;
  localparam int N_WSU = ns2cyc(T_SA_NS, CLK_NS);
  localparam int N_PWE = imax(imax(ns2cyc(T_PWE_NS, CLK_NS), ns2cyc(T_SD_NS, CLK_NS)),
                              imax(ns2cyc(T_AW_NS, CLK_NS) - N_WSU, 1));
  localparam int N_WH  = ns2cyc(T_HA_NS, CLK_NS);
  localparam int N_WC  = ns2cyc(T_WC_NS, CLK_NS);
  localparam int N_RD  = imax(ns2cyc(T_AA_NS, CLK_NS), ns2cyc(T_DOE_NS, CLK_NS));
  localparam int N_HZ  = ns2cyc(T_HZ_NS, CLK_NS);
  localparam int N_RC  = ns2cyc(T_RC_NS, CLK_NS);

  st_e              st, nxt;
  logic             accept;
  logic             ph_load, ph_zero, cyc_zero;
  logic [CNT_W-1:0] ph_val, cyc_val;
  logic [LANES-1:0] r_mask, pin_mask, lane_n;

  assign req_ready = (st == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign cyc_val   = req_write ? CNT_W'(N_WC - 1) : CNT_W'(N_RC - 1);
  assign pin_mask  = accept ? req_mask : r_mask;

  always_comb begin
    nxt     = st;
    ph_load = 1'b0;
    ph_val  = '0;
    unique case (st)
      ST_IDLE: if (req_valid) begin
        nxt     = req_write ? ST_WSETUP : ST_RACC;
        ph_load = 1'b1;
        ph_val  = req_write ? CNT_W'(N_WSU - 1) : CNT_W'(N_RD - 1);
      end
      ST_WSETUP: if (ph_zero) begin
        nxt = ST_WPULSE; ph_load = 1'b1; ph_val = CNT_W'(N_PWE - 1);
      end
      ST_WPULSE: if (ph_zero) begin
        nxt = ST_WHOLD; ph_load = 1'b1; ph_val = CNT_W'(N_WH - 1);
      end
      ST_WHOLD:  if (ph_zero) nxt = cyc_zero ? ST_IDLE : ST_CWAIT;
      ST_RACC: if (ph_zero) begin
        nxt = ST_RRECOV; ph_load = 1'b1; ph_val = CNT_W'(N_HZ - 1);
      end
      ST_RRECOV: if (ph_zero) nxt = cyc_zero ? ST_IDLE : ST_CWAIT;
      ST_CWAIT:  if (cyc_zero) nxt = ST_IDLE;
      default:   nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_IDLE;
    else        st <= nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_mask     <= '0;
      mem_addr   <= '0;
      mem_dq_out <= '0;
    end else if (accept) begin
      r_mask     <= req_mask;
      mem_addr   <= req_addr;
      mem_dq_out <= req_wdata;
    end
  end

  sram_ctl_cnt #(.W(CNT_W)) u_phase (
    .clk(clk), .rst_n(rst_n), .load(ph_load), .val(ph_val), .zero(ph_zero)
  );

  sram_ctl_cnt #(.W(CNT_W)) u_cycle (
    .clk(clk), .rst_n(rst_n), .load(accept), .val(cyc_val), .zero(cyc_zero)
  );

  sram_ctl_pins #(.LANES(LANES)) u_pins (
    .clk(clk), .rst_n(rst_n), .nxt(nxt), .mask(pin_mask),
    .ce_n(mem_ce_n), .we_n(mem_we_n), .oe_n(mem_oe_n),
    .lane_n(lane_n), .dq_oe(mem_dq_oe)
  );

  assign mem_lb_n = lane_n[0];
  assign mem_ub_n = lane_n[1];

  // read capture on the last access cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsp_valid <= 1'b0;
    else        rsp_valid <= (st == ST_RACC) && ph_zero;
  end

  for (genvar l = 0; l < LANES; l++) begin : g_cap
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        rsp_rdata[l*8 +: 8] <= '0;
      else if ((st == ST_RACC) && ph_zero)
        rsp_rdata[l*8 +: 8] <= r_mask[l] ? mem_dq_in[l*8 +: 8] : 8'h00;
    end
  end
endmodule

// File: rtl/sram_ctl_chk.sv
module sram_ctl_chk
  import sram_ctl_pkg::*;
#(
  parameter int CLK_NS   = 10,
  parameter int T_PWE_NS = 40,
  parameter int T_HZ_NS  = 20
) (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic        rsp_valid,
  input logic        mem_ce_n,
  input logic        mem_we_n,
  input logic        mem_oe_n,
  input logic        mem_lb_n,
  input logic        mem_ub_n,
  input logic [15:0] mem_addr,
  input logic        mem_dq_oe
);
  localparam int MIN_PWE = ns2cyc(T_PWE_NS, CLK_NS);
  localparam int MIN_HZ  = ns2cyc(T_HZ_NS, CLK_NS);

  logic [7:0] we_lo_cnt, oe_hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_lo_cnt <= '0;
      oe_hi_cnt <= 8'hFF;
    end else begin
      we_lo_cnt <= mem_we_n ? 8'd0 : ((we_lo_cnt == 8'hFF) ? we_lo_cnt : we_lo_cnt + 8'd1);
      oe_hi_cnt <= !mem_oe_n ? 8'd0 : ((oe_hi_cnt == 8'hFF) ? oe_hi_cnt : oe_hi_cnt + 8'd1);
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_ce_n && mem_we_n && mem_oe_n && mem_lb_n && mem_ub_n && !mem_dq_oe)); // R1
  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready); // R2
  AST_STROBE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (we_lo_cnt >= 8'(MIN_PWE))); // R3
  AST_STROBE_FRAMED: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_ce_n && mem_oe_n)); // R4
  AST_WE_ENDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> !mem_ce_n); // R4
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R6
  AST_NO_BUS_FIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n); // R8
  AST_BUS_FLOATED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dq_oe) |-> (oe_hi_cnt >= 8'(MIN_HZ))); // R8
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr)); // R9
endmodule

bind sram_ctl sram_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
  .mem_oe_n(mem_oe_n), .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n),
  .mem_addr(mem_addr), .mem_dq_oe(mem_dq_oe)
);

// File: tb/sram_ctl_test.sv
module sram_ctl_test;
  localparam int N_PWE = 4;
  localparam int N_HZ  = 2;
  localparam int BUSY_W = 6;
  localparam int BUSY_R = 8;
  localparam int NV = 12;
  // {write, mask[1:0], addr[15:0], wdata[15:0], expected read[15:0]}
  localparam logic [50:0] VEC [NV] = '{
    {1'b1, 2'b11, 16'h0010, 16'h1234, 16'h0000},
    {1'b0, 2'b11, 16'h0010, 16'h0000, 16'h1234},
    {1'b1, 2'b01, 16'h0010, 16'hABCD, 16'h0000},
    {1'b0, 2'b11, 16'h0010, 16'h0000, 16'h12CD},
    {1'b1, 2'b10, 16'h0010, 16'h77EE, 16'h0000},
    {1'b0, 2'b01, 16'h0010, 16'h0000, 16'h00CD},
    {1'b0, 2'b10, 16'h0010, 16'h0000, 16'h7700},
    {1'b1, 2'b00, 16'h0010, 16'hFFFF, 16'h0000},
    {1'b0, 2'b11, 16'h0010, 16'h0000, 16'h77CD},
    {1'b1, 2'b11, 16'h00FF, 16'h5A5A, 16'h0000},
    {1'b0, 2'b11, 16'h00FF, 16'h0000, 16'h5A5A},
    {1'b0, 2'b00, 16'h00FF, 16'h0000, 16'h0000}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [15:0] req_addr = '0, req_wdata = '0;
  logic [1:0] req_mask = '0;
  logic req_ready, rsp_valid, mem_ce_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n, mem_dq_oe;
  logic [15:0] rsp_rdata, mem_addr, mem_dq_out, mem_dq_in;

  int nvec = 0, nfail = 0, cyc = 0;
  logic [15:0] mem [0:255];
  int we_run = 0, last_pulse = 0, oe_hi_run = 100, gap_err = 0, drv_err = 0, addr_err = 0;
  logic lo_seen, hi_seen, prev_ce_low = 1'b0;
  logic [15:0] prev_addr = '0;

  always #2 clk = ~clk;

  sram_ctl uut (.*);

  assign mem_dq_in = (!mem_ce_n && !mem_oe_n && mem_we_n) ?
    {mem_ub_n ? 8'hA5 : mem[mem_addr[7:0]][15:8], mem_lb_n ? 8'hA5 : mem[mem_addr[7:0]][7:0]} : 16'hFFFF;

  always @(negedge clk) begin
    if (!mem_ce_n && !mem_we_n && mem_dq_oe) begin
      if (!mem_lb_n) mem[mem_addr[7:0]][7:0]  = mem_dq_out[7:0];
      if (!mem_ub_n) mem[mem_addr[7:0]][15:8] = mem_dq_out[15:8];
    end
    if (!mem_we_n) we_run++;
    else if (we_run != 0) begin last_pulse = we_run; we_run = 0; end
    if (!mem_lb_n) lo_seen = 1'b1;
    if (!mem_ub_n) hi_seen = 1'b1;
    if (mem_dq_oe && !mem_oe_n) drv_err++;
    if (mem_dq_oe && oe_hi_run > 0 && oe_hi_run < N_HZ + 1 && !mem_ce_n && mem_we_n && prev_ce_low == 1'b0)
      gap_err++;
    if (mem_oe_n && !mem_dq_oe) oe_hi_run++;
    else if (!mem_oe_n) oe_hi_run = 0;
    if (!mem_ce_n && prev_ce_low && mem_addr != prev_addr) addr_err++;
    prev_ce_low = !mem_ce_n;
    prev_addr   = mem_addr;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic txn(input logic w, input logic [1:0] m, input logic [15:0] a, input logic [15:0] d,
                     output int busy, output logic [15:0] rd, output logic got);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_mask = m; req_addr = a; req_wdata = d;
    lo_seen = 1'b0; hi_seen = 1'b0;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    busy = 0; got = 1'b0; rd = '0;
    while (!req_ready) begin
      if (rsp_valid) begin got = 1'b1; rd = rsp_rdata; end
      busy++;
      @(negedge clk);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      nfail++;
      $display("FAIL watchdog: actual %0d expected below 100000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    int busy;
    logic [15:0] rd;
    logic got;
    for (int i = 0; i < 256; i++) mem[i] = '0;
    lo_seen = 1'b0; hi_seen = 1'b0;
    repeat (3) @(negedge clk);
    // R1: state held in reset and just after release
    chk("R1 reset pins", {mem_ce_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n, mem_dq_oe, rsp_valid, req_ready},
        8'b11111001);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle pins", {mem_ce_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n, mem_dq_oe, rsp_valid, req_ready},
        8'b11111001);

    for (int v = 0; v < NV; v++) begin
      logic vw; logic [1:0] vm; logic [15:0] va, vd, ve;
      {vw, vm, va, vd, ve} = VEC[v];
      last_pulse = 0;
      txn(vw, vm, va, vd, busy, rd, got);
      if (vw) begin
        chk("R2 write busy", busy, BUSY_W);
        chk("R3 strobe width", last_pulse, N_PWE);
        chk("R10 write cycle ns", busy * 10 >= 55, 1);
        chk("R6 no rsp on write", got, 0);
      end else begin
        chk("R2 read busy", busy, BUSY_R);
        chk("R6 rsp pulse", got, 1);
        chk("R6 R7 read data", rd, ve);
        chk("R5 no strobe on read", last_pulse, 0);
      end
      chk("R7 lane pins", {hi_seen, lo_seen}, vm);
      chk("R1 idle after", {mem_ce_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n, mem_dq_oe}, 6'b111110);
    end

    // R5: measure the read access window directly
    begin
      int oe_lo;
      oe_lo = 0;
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b0; req_mask = 2'b11; req_addr = 16'h0010;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      while (!req_ready) begin
        if (!mem_oe_n && !mem_ce_n && mem_we_n) oe_lo++;
        @(negedge clk);
      end
      chk("R5 access window", oe_lo, 6);
    end

    // R8: write straight after a read, then the bus-safety counters
    txn(1'b0, 2'b11, 16'h00FF, 16'h0000, busy, rd, got);
    txn(1'b1, 2'b11, 16'h0020, 16'hC3C3, busy, rd, got);
    txn(1'b0, 2'b11, 16'h0020, 16'h0000, busy, rd, got);
    chk("R8 write after read data", rd, 16'hC3C3);
    chk("R8 driver vs output enable", drv_err, 0);
    chk("R8 float gap", gap_err, 0);
    chk("R9 address held", addr_err, 0);
    // R4: strobe framed by chip select, observed on a fresh write
    begin
      logic bad;
      bad = 1'b0;
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b1; req_mask = 2'b01; req_addr = 16'h0030; req_wdata = 16'h0042;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      while (!req_ready) begin
        if (!mem_we_n && (mem_ce_n || !mem_oe_n)) bad = 1'b1;
        @(negedge clk);
      end
      chk("R4 strobe framed", bad, 0);
      chk("R4 hold kept write", mem[8'h30], 16'h0042);
    end

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule